// File: doc/BRIEF.md
# Host Write-Posting Burst Controller

This block sits between a simple host port and a system-memory DMA master. Host data writes are posted into an eight-word queue and leave for memory as bursts of up to four words. Data writes come in two kinds. Autoincrementing writes advance a running word address. Fixed-address writes go to the current address without moving it. When the queue holds fewer than four words and the host goes quiet, an inactivity timer drains the leftovers as one short burst.

An address-register write or a fixed-address write first forces out everything still queued. The queued words go to memory at the addresses of the old stream. Only then does the new address take effect, or the single-word write go out. The host is held off through a combinational ready signal. For autoincrementing writes this happens only while the queue is full. For the two flushing operations it happens until the queue and the memory engine are both idle.

On the memory side there is a request/grant handshake that carries the burst address and length. After the grant comes a data phase with one beat offered per cycle, and each beat-acknowledge removes one word from the queue.

Top module: `wpost_burst_ctrl`

## Requirements
- R1: The queue holds eight words. An autoincrementing data write (`host_wr`=1, `host_autoinc`=1) is accepted on a rising edge where `host_rdy` is high. `host_rdy` is low for such a write while eight words are queued, and it stays low until a beat acknowledge frees a slot.
- R2: With no timeout, no flush and no fixed-address write pending, `mem_req` stays low while fewer than four words are queued. Any burst started with four or more words queued has `mem_len` = 4.
- R3: While four or more words remain queued, the next four-word request follows the end of the previous burst directly and does not wait for the timer.
- R4: The inactivity timer restarts on every accepted word and is held cleared while the queue is empty. When 1 to 3 words are queued and no other event intervenes, `mem_req` rises at the 161st rising edge after the edge that accepted the last word (a 160-cycle period), and `mem_len` equals the queued count.
- R5: An address-register write (`host_addr_wr`=1, address on `host_wdata`) is held off while any word is queued or a burst is in flight. The queued words are sent at once, without waiting for the timer, at their old-stream addresses. Later autoincrementing words start at the loaded address.
- R6: A fixed-address data write (`host_wr`=1, `host_autoinc`=0) is held off in the same way as in R5. It is then sent as a burst with `mem_len` = 1 at the current address, and the running address does not advance.
- R7: A burst's `mem_addr` is the address of its oldest queued word. Consecutive autoincrementing words take consecutive word addresses (step 1).
- R8: `mem_req` holds `mem_addr` and `mem_len` (binary value 1 to 4) steady until a rising edge with `mem_gnt` high. From the next cycle, `mem_wvalid` is high with `mem_wdata` equal to the oldest queued word, and one word leaves on each rising edge with `mem_ack` high. After `mem_len` acknowledged beats the engine returns to idle. `mem_req` and `mem_wvalid` are never high together. Words reach memory in acceptance order.
- R9: During and after reset the queue is empty, the running address is 0, `mem_req` and `mem_wvalid` are low, and `host_rdy` is high for an autoincrementing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host data write strobe, held until accepted |
| host_autoinc | input | 1 | Qualifies `host_wr`: 1 autoincrement, 0 fixed address |
| host_addr_wr | input | 1 | Host address-register write strobe, held until accepted |
| host_wdata | input | DW | Write data, or the new word address for an address write |
| host_rdy | output | 1 | Current host operation is accepted at the next rising edge |
| mem_req | output | 1 | Burst request |
| mem_addr | output | AW | Word address of the burst's first beat |
| mem_len | output | 3 | Burst length, 1 to 4 |
| mem_gnt | input | 1 | Grant for the pending request |
| mem_wvalid | output | 1 | A data beat is offered |
| mem_wdata | output | DW | Data of the offered beat |
| mem_ack | input | 1 | Beat accepted by memory |

## Verification
The checker assumes a single well-behaved host. It never raises `host_wr` and `host_addr_wr` together, and it holds a strobe and its data steady until the operation is accepted. On the memory side, `mem_gnt` comes only while `mem_req` is high and `mem_ack` only while `mem_wvalid` is high. The bench's host task drives exactly one operation at a time and drops it right after the accepting edge. The bench's responder derives grant and acknowledge from the design's own request and valid outputs, with random delays that include long stalls.

// File: rtl/wpost_pkg.sv
package wpost_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_REQ  = 2'd1,
    ENG_DATA = 2'd2
  } eng_state_e;

  // Length of the next burst: one beat for a fixed-address write,
  // otherwise everything queued up to the burst size.
  function automatic int burst_len_pick(int queued, int max_beats, bit single);
    if (single) return 1;
    if (queued < max_beats) return queued;
    return max_beats;
  endfunction

  // A burst is wanted when data is queued and any drain reason holds.
  function automatic bit burst_wanted(int queued, int max_beats, bit expired,
                                      bit flushing, bit single);
    if (queued == 0) return 1'b0;
    return (queued >= max_beats) || expired || flushing || single;
  endfunction

endpackage

// File: rtl/wpost_fifo.sv
module wpost_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= ptr_next(wp);
      if (pop)  rp <= ptr_next(rp);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assign rdata = store[rp];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/wpost_timer.sv
module wpost_timer #(
  parameter int PERIOD = 160,
  localparam int TW    = $clog2(PERIOD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic idle,
  output logic expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (restart || idle)     cnt <= '0;
    else if (cnt != TW'(PERIOD))  cnt <= cnt + TW'(1);
  end

  assign expired = (cnt == TW'(PERIOD));

endmodule

// File: rtl/wpost_burst_eng.sv
module wpost_burst_eng
  import wpost_pkg::*;
#(
  parameter int AW    = 32,
  parameter int BURST = 4,
  parameter int CW    = 4,
  parameter int LW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] queued,
  input  logic          expired,
  input  logic          flushing,
  input  logic          single_pend,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_val,
  input  logic          mem_gnt,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [LW-1:0] mem_len,
  output logic          mem_wvalid,
  output logic          pop,
  output logic          start,
  output logic          busy
);

  eng_state_e    state;
  logic [LW-1:0] len_q, beat_q, len_pick;
  logic [AW-1:0] head_q, base_q;
  logic          solo_cur;
  logic          last_beat;

  assign len_pick  = LW'(burst_len_pick(32'(queued), BURST, single_pend));
  assign start     = (state == ENG_IDLE) &&
                     burst_wanted(32'(queued), BURST, expired, flushing, single_pend);
  assign last_beat = (beat_q == len_q - LW'(1));
  assign pop       = (state == ENG_DATA) && mem_ack;
  assign busy      = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      len_q    <= '0;
      beat_q   <= '0;
      head_q   <= '0;
      base_q   <= '0;
      solo_cur <= 1'b0;
    end else begin
      // head_q tracks the address of the oldest queued word
      if (addr_load)              head_q <= addr_val;
      else if (pop && !solo_cur)  head_q <= head_q + AW'(1);

      case (state)
        ENG_IDLE: if (start) begin
          state    <= ENG_REQ;
          len_q    <= len_pick;
          base_q   <= head_q;
          solo_cur <= single_pend;
        end
        ENG_REQ: if (mem_gnt) begin
          state  <= ENG_DATA;
          beat_q <= '0;
        end
        ENG_DATA: if (mem_ack) begin
          beat_q <= beat_q + LW'(1);
          if (last_beat) state <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign mem_req    = (state == ENG_REQ);
  assign mem_addr   = base_q;
  assign mem_len    = len_q;
  assign mem_wvalid = (state == ENG_DATA);

endmodule

// File: rtl/wpost_burst_ctrl.sv
module wpost_burst_ctrl #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int DEPTH   = 8,
  parameter int BURST   = 4,
  parameter int TIMEOUT = 160,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int LW     = $clog2(BURST) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_autoinc,
  input  logic          host_addr_wr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_rdy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [LW-1:0] mem_len,
  input  logic          mem_gnt,
  output logic          mem_wvalid,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack
);

  // Named internal events, visible to the checker
  logic          flush_pend;   // a flushing host operation is waiting
  logic          quiet;        // queue empty, engine idle, nothing pending
  logic          push;
  logic          pop;
  logic          addr_take;
  logic          solo_take;
  logic          solo_q;
  logic          eng_start;
  logic          eng_busy;
  logic          tmo_expired;
  logic          fifo_full;
  logic          fifo_empty;
  logic [CW-1:0] fifo_count;

  assign flush_pend = host_addr_wr || (host_wr && !host_autoinc);
  assign quiet      = fifo_empty && !eng_busy && !solo_q;
  assign host_rdy   = flush_pend ? quiet : !fifo_full;
  assign addr_take  = host_addr_wr && host_rdy;
  assign push       = host_wr && !host_addr_wr && host_rdy;
  assign solo_take  = push && !host_autoinc;

  always_ff @(posedge clk) begin
    if (!rst_n)         solo_q <= 1'b0;
    else if (solo_take) solo_q <= 1'b1;
    else if (eng_start) solo_q <= 1'b0;
  end

  wpost_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (host_wdata),
    .pop   (pop),
    .rdata (mem_wdata),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  wpost_timer #(.PERIOD(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (push),
    .idle    (fifo_empty),
    .expired (tmo_expired)
  );

  wpost_burst_eng #(.AW(AW), .BURST(BURST), .CW(CW), .LW(LW)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .queued      (fifo_count),
    .expired     (tmo_expired),
    .flushing    (flush_pend),
    .single_pend (solo_q),
    .addr_load   (addr_take),
    .addr_val    (AW'(host_wdata)),
    .mem_gnt     (mem_gnt),
    .mem_ack     (mem_ack),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_len     (mem_len),
    .mem_wvalid  (mem_wvalid),
    .pop         (pop),
    .start       (eng_start),
    .busy        (eng_busy)
  );

endmodule

// File: rtl/wpost_burst_chk.sv
module wpost_burst_chk #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int BURST = 4,
  parameter int CW    = 4,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic          host_autoinc,
  input logic          host_addr_wr,
  input logic          host_rdy,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic [LW-1:0] mem_len,
  input logic          mem_gnt,
  input logic          mem_wvalid,
  input logic          mem_ack,
  input logic [CW-1:0] fifo_count,
  input logic          eng_start,
  input logic          tmo_expired,
  input logic          flush_pend,
  input logic          solo_q
);

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CW'(DEPTH)) && host_wr && host_autoinc && !host_addr_wr |-> !host_rdy); // R1

  AST_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start && !tmo_expired && !flush_pend && !solo_q |-> fifo_count >= CW'(BURST)); // R2

  AST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start && !solo_q && fifo_count >= CW'(BURST) |=> mem_len == LW'(BURST)); // R2

  AST_SHORT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start && !solo_q && fifo_count < CW'(BURST)
      |=> 32'(mem_len) == 32'($past(fifo_count))); // R4

  AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count == '0 |=> !tmo_expired); // R4

  AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pend && fifo_count != '0 |-> !host_rdy); // R5

  AST_SOLO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start && solo_q |=> mem_len == LW'(1)); // R6

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_len)); // R8

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_wvalid)); // R8

  AST_BEAT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> fifo_count != '0); // R8

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_len != '0 && mem_len <= LW'(BURST)); // R8

endmodule

bind wpost_burst_ctrl wpost_burst_chk #(
  .AW(AW), .DEPTH(DEPTH), .BURST(BURST), .CW(CW), .LW(LW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr      (host_wr),
  .host_autoinc (host_autoinc),
  .host_addr_wr (host_addr_wr),
  .host_rdy     (host_rdy),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_len      (mem_len),
  .mem_gnt      (mem_gnt),
  .mem_wvalid   (mem_wvalid),
  .mem_ack      (mem_ack),
  .fifo_count   (fifo_count),
  .eng_start    (eng_start),
  .tmo_expired  (tmo_expired),
  .flush_pend   (flush_pend),
  .solo_q       (solo_q)
);

// File: tb/wpost_burst_ctrl_test.sv
module wpost_burst_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, DEPTH = 8, BURST = 4, TIMEOUT = 160, LW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, host_autoinc = 1'b0, host_addr_wr = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic host_rdy, mem_req, mem_wvalid;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_len;
  logic [DW-1:0] mem_wdata;
  logic mem_gnt = 1'b0, mem_ack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpost_burst_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .BURST(BURST), .TIMEOUT(TIMEOUT)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_autoinc(host_autoinc),
    .host_addr_wr(host_addr_wr), .host_wdata(host_wdata), .host_rdy(host_rdy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt),
    .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .mem_ack(mem_ack));

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [AW-1:0] exp_addr_q[$];
  logic [DW-1:0] exp_data_q[$];
  int len_log[$];
  int gnt_cyc[$];
  logic [AW-1:0] base_log[$];
  logic [AW-1:0] model_addr = '0;
  logic [AW-1:0] cur_base = '0;
  int beat_idx = 0;
  bit mem_hold = 0;
  int gnt_pct = 100, ack_pct = 100;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected-value functions restating the requirements
  function automatic int exp_len(int queued, bit single);   // R2 R4 R6
    if (single) return 1;
    return (queued < BURST) ? queued : BURST;
  endfunction

  function automatic logic [AW-1:0] exp_next(logic [AW-1:0] a, bit autoinc); // R6 R7
    return autoinc ? a + AW'(1) : a;
  endfunction

  task automatic check_eq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Memory responder: grant and acknowledge decided away from the edge
  initial begin
    forever begin
      @(negedge clk);
      mem_gnt = mem_req && !mem_hold && ($urandom_range(99) < 32'(gnt_pct));
      if (mem_gnt) begin
        len_log.push_back(int'(mem_len));
        gnt_cyc.push_back(cyc);
        base_log.push_back(mem_addr);
        cur_base = mem_addr;
        beat_idx = 0;
      end
      mem_ack = mem_wvalid && ($urandom_range(99) < 32'(ack_pct));
      if (mem_ack) begin
        if (exp_data_q.size() == 0) begin
          check_eq("R8", "unexpected beat", 1, 0);
        end else begin
          check_eq("R7", "beat address", longint'(cur_base + AW'(beat_idx)),
                   longint'(exp_addr_q.pop_front()));
          check_eq("R8", "beat data", longint'(mem_wdata), longint'(exp_data_q.pop_front()));
        end
        beat_idx++;
      end
    end
  end

  task automatic host_op(input bit is_addr, input bit autoinc, input logic [DW-1:0] val,
                         output int waited);
    @(negedge clk);
    host_addr_wr = is_addr;
    host_wr      = !is_addr;
    host_autoinc = autoinc;
    host_wdata   = val;
    waited = 0;
    #1;
    while (!host_rdy && waited < 5000) begin
      @(negedge clk);
      #1;
      waited++;
    end
    if (waited >= 5000) check_eq("R1", "host op never accepted", 0, 1);
    @(posedge clk);
    if (is_addr) model_addr = AW'(val);
    else begin
      exp_addr_q.push_back(model_addr);
      exp_data_q.push_back(val);
      model_addr = exp_next(model_addr, autoinc);
    end
    #1;
    host_wr = 1'b0;
    host_addr_wr = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_data_q.size() != 0 || mem_req || mem_wvalid) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check_eq("R8", "queue drained", longint'(exp_data_q.size()), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int w;
    int sum_req;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    // R9: reset state
    check_eq("R9", "host_rdy in reset", host_rdy, 1);
    check_eq("R9", "mem_req in reset", mem_req, 0);
    check_eq("R9", "mem_wvalid in reset", mem_wvalid, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: three words do not raise a request
    for (int i = 0; i < 3; i++) host_op(0, 1, 32'hA0 + 32'(i), w);
    sum_req = 0;
    for (int i = 0; i < 120; i++) begin @(negedge clk); sum_req += int'(mem_req); end
    check_eq("R2", "request before four words", sum_req, 0);
    host_op(0, 1, 32'hA3, w);
    drain();
    check_eq("R2", "burst length at threshold", len_log[$], exp_len(4, 0));
    check_eq("R9", "first burst address after reset", longint'(base_log[$]), 0);

    // R4: timeout drains 1..3 words, counted from the last word
    for (int k = 1; k <= 3; k++) begin
      int n;
      for (int i = 0; i < k; i++) begin
        if (k == 2 && i == 1) idle(100);
        host_op(0, 1, 32'hB0 + 32'(k * 8 + i), w);
      end
      n = 0;
      do begin @(posedge clk); #1; n++; end while (!mem_req && n < 400);
      check_eq("R4", "edges from last word to request", n, TIMEOUT + 1);
      drain();
      check_eq("R4", "short burst length", len_log[$], exp_len(k, 0));
    end

    // R1 and R3: fill to eight with grants held off, then release
    mem_hold = 1;
    for (int i = 0; i < DEPTH; i++) host_op(0, 1, 32'hC0 + 32'(i), w);
    len_log.delete();
    gnt_cyc.delete();
    fork
      host_op(0, 1, 32'hC8, w);
      begin
        idle(4);
        #2;
        check_eq("R1", "host_rdy while full", host_rdy, 0);
        idle(6);
        mem_hold = 0;
      end
    join
    check_eq("R1", "ninth write waited for space", longint'(w >= 9), 1);
    drain();
    check_eq("R3", "bursts after release", len_log.size(), 3);
    if (len_log.size() == 3) begin
      check_eq("R3", "first burst length", len_log[0], 4);
      check_eq("R3", "second burst length", len_log[1], 4);
      check_eq("R4", "leftover burst length", len_log[2], 1);
      check_eq("R3", "second burst back to back", longint'(gnt_cyc[1] - gnt_cyc[0] <= 8), 1);
    end

    // R5: address write flushes old-stream words first
    host_op(0, 1, 32'hD0, w);
    host_op(0, 1, 32'hD1, w);
    host_op(1, 0, 32'h100, w);
    check_eq("R5", "address write held during flush", longint'(w > 0), 1);
    check_eq("R5", "flush without timer wait", longint'(w < 20), 1);
    for (int i = 0; i < 4; i++) host_op(0, 1, 32'hD8 + 32'(i), w);
    drain();
    check_eq("R5", "new stream base address", longint'(base_log[$]), 32'h100);

    // R6: fixed-address writes after queued words
    for (int i = 0; i < 3; i++) host_op(0, 1, 32'hE0 + 32'(i), w);
    len_log.delete();
    base_log.delete();
    host_op(0, 0, 32'hE5, w);
    host_op(0, 0, 32'hE6, w);
    check_eq("R6", "second fixed write held", longint'(w > 0), 1);
    drain();
    check_eq("R6", "burst count", len_log.size(), 3);
    if (len_log.size() == 3) begin
      check_eq("R6", "flush burst length", len_log[0], exp_len(3, 0));
      check_eq("R6", "single burst length", len_log[1], exp_len(0, 1));
      check_eq("R6", "fixed writes share address", longint'(base_log[2]), longint'(base_log[1]));
      check_eq("R6", "fixed write address", longint'(base_log[1]), 32'h107);
    end

    // Random mix: checked beat by beat against the model (R7 R8)
    gnt_pct = 60;
    ack_pct = 70;
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(99));
      if (r < 6)       host_op(1, 0, $urandom_range(32'hFFFF), w);
      else if (r < 15) host_op(0, 0, $urandom, w);
      else             host_op(0, 1, $urandom, w);
      r = int'($urandom_range(99));
      if (r < 3)       idle(200);
      else if (r < 30) idle(int'($urandom_range(3)));
    end
    drain();
    idle(10);
    check_eq("R8", "engine idle at end", longint'(mem_req || mem_wvalid), 0);
    done = 1;
  end

  initial begin
    int t = 0;
    while (!done && t < 190000) begin @(negedge clk); t++; end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", t, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule